// File: doc/BRIEF.md
# Two-Channel Indirect Register Access Unit

This unit sits between a simple host bus and the two channels of a serial controller. Each channel has two host ports. The control port reaches all of the channel's internal registers through a 4-bit index. The data port reaches the transmit and receive bytes directly. To reach an indexed register, the host makes two control accesses. The first control write loads the index. The second control access, a read or a write, is steered to the selected register. After that second access the index drops back to zero.

One master register is shared by both channels, and either channel can reach it. The top two bits of a write to the master register form a reset command. The command can clear channel A, clear channel B, or clear the whole unit. The stored register contents leave the block on a per-channel configuration bus, where the baud generator and the serial channels pick them up. Load and pop strobes mark each transmit byte and each consumed receive byte.

Top module: `dual_chan_regif`

## Requirements
- R1: While rst_n is low, every index is zero, every configuration byte is 0x00 and no strobe is active.
- R2: A control write made while the channel's index is zero, with bits 7:4 of the byte all zero, loads bits 3:0 into that channel's index. The next control access on that channel then reaches register number bits 3:0.
- R3: A control read or write made while the index is non-zero returns the index to zero at the following clock edge.
- R4: A control write made while the index is zero, with any of bits 7:4 set, leaves the index at zero and alters no register.
- R5: A control read made while the index is zero returns that channel's status_in byte combinationally in the same cycle, and leaves the index at zero.
- R6: A data-port write, or a control write to index 8, raises that channel's tx_load bit for that cycle and presents the byte on tx_byte. At most one tx_load bit is high in any cycle.
- R7: A data-port read, or a control read of index 8, returns that channel's rx_byte and raises its rx_pop bit for that cycle. A data-port access never changes the index.
- R8: Writes to indexes 1 to 7 and 10 to 15 are stored per channel and appear on chan_cfg[channel][index]. Reads of indexes 12 and 13 return the values stored at 12 and 13.
- R9: Index 9 is one master register shared by both channels. A write to it from either channel stores bits 5:0 with bits 7:6 read as zero, and the result shows at chan_cfg[0][9] and at chan_cfg[1][9].
- R10: Bits 7:6 of a master write select a reset. 2'b10 clears channel A, 2'b01 clears channel B, 2'b11 clears both channels and the master register, and 2'b00 clears nothing. A cleared channel has its index and its stored bytes set to zero at the next edge, and its chan_rst bit is high during the write cycle.
- R11: Control reads of indexes that are not 0, 8, 12 or 13 return 0x00.
- R12: Each channel's index is independent. Accesses to one channel never move the other channel's index, except through the reset command of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| chan | input | 1 | Channel select, 0 = A, 1 = B |
| dport | input | 1 | 1 = data port, 0 = control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid in the read cycle, 0 otherwise |
| status_in | input | 2x8 | Per-channel status byte returned at index 0 |
| rx_byte | input | 2x8 | Per-channel received byte |
| tx_load | output | 2 | Per-channel transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_pop | output | 2 | Per-channel receive byte consumed strobe |
| chan_rst | output | 2 | Per-channel reset pulse from the master command |
| chan_cfg | output | 2x16x8 | Per-channel register contents by index |

## Verification
The assertions assume that the host makes at most one access per cycle. This means one channel select and one port select, so at most one channel can write the master register or load a transmit byte at a time. The assertions also assume that status_in and rx_byte are stable while they are read. The stimulus drives every bus cycle on the falling clock edge with exactly one channel and port, and it holds the status and receive bytes constant. That keeps the stimulus within these assumptions. The index checks rest on these same conditions: a pointed access clears the index, and a data access or a rejected command leaves it unchanged.

// File: rtl/regif_pkg.sv
package regif_pkg;
  localparam int NCH   = 2;
  localparam int DW    = 8;
  localparam int PTR_W = 4;
  localparam int NREG  = 1 << PTR_W;
  localparam int CSEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  localparam logic [PTR_W-1:0] IDX_STAT   = PTR_W'(0);
  localparam logic [PTR_W-1:0] IDX_XFER   = PTR_W'(8);
  localparam logic [PTR_W-1:0] IDX_MASTER = PTR_W'(9);
  localparam logic [PTR_W-1:0] IDX_TC_LO  = PTR_W'(12);
  localparam logic [PTR_W-1:0] IDX_TC_HI  = PTR_W'(13);

  localparam int KEEP_W = DW - 2;

  typedef enum logic [1:0] {
    RST_NONE = 2'b00,
    RST_CHB  = 2'b01,
    RST_CHA  = 2'b10,
    RST_ALL  = 2'b11
  } rst_cmd_e;

  function automatic logic is_ptr_load(input logic [DW-1:0] b);
    return b[DW-1:PTR_W] == '0;
  endfunction

  function automatic rst_cmd_e rst_code(input logic [DW-1:0] b);
    return rst_cmd_e'(b[DW-1:DW-2]);
  endfunction

  function automatic logic [NCH-1:0] rst_targets(input logic [DW-1:0] b);
    case (rst_code(b))
      RST_ALL: return '1;
      RST_CHA: return NCH'(1);
      RST_CHB: return NCH'(2);
      default: return '0;
    endcase
  endfunction

  function automatic logic has_store(input int idx);
    return (idx != int'(IDX_STAT)) && (idx != int'(IDX_XFER)) && (idx != int'(IDX_MASTER));
  endfunction
endpackage

// File: rtl/regif_master.sv
module regif_master
  import regif_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] wr9,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  master,
  output logic [NCH-1:0] clr
);
  logic any_wr;
  assign any_wr = |wr9;
  assign clr    = any_wr ? rst_targets(wdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      master <= '0;
    else if (any_wr)
      master <= (rst_code(wdata) == RST_ALL) ? '0 : {2'b00, wdata[KEEP_W-1:0]};
  end

  // R9
  master_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr9));

  // R10
  master_full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && rst_code(wdata) == RST_ALL) |=> (master == '0));
endmodule

// File: rtl/regif_chan.sv
module regif_chan
  import regif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     we,
  input  logic                     dport,
  input  logic [DW-1:0]            wdata,
  input  logic                     clr,
  input  logic [DW-1:0]            status,
  input  logic [DW-1:0]            rx_byte,
  input  logic [DW-1:0]            master,
  output logic [PTR_W-1:0]         ptr,
  output logic [NREG-1:0][DW-1:0]  cfg,
  output logic                     tx_load,
  output logic                     rx_pop,
  output logic                     wr9_hit,
  output logic [DW-1:0]            rd_data
);
  logic ctl_acc, pointed, ptr_load, wr_hit;

  assign ctl_acc  = sel && !dport;
  assign pointed  = ctl_acc && (ptr != IDX_STAT);
  assign ptr_load = ctl_acc && we && (ptr == IDX_STAT) && is_ptr_load(wdata);
  assign wr_hit   = pointed && we;
  assign wr9_hit  = wr_hit && (ptr == IDX_MASTER);
  assign tx_load  = sel && we && (dport || ptr == IDX_XFER);
  assign rx_pop   = sel && !we && (dport || ptr == IDX_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (clr)
      ptr <= '0;
    else if (ptr_load)
      ptr <= wdata[PTR_W-1:0];
    else if (pointed)
      ptr <= '0;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(IDX_MASTER)) begin : g_shared
      assign cfg[i] = master;
    end else if (!has_store(i)) begin : g_none
      assign cfg[i] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (clr)
          q <= '0;
        else if (wr_hit && ptr == PTR_W'(i))
          q <= wdata;
      end
      assign cfg[i] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (sel && !we) begin
      if (dport)
        rd_data = rx_byte;
      else
        case (ptr)
          IDX_STAT:  rd_data = status;
          IDX_XFER:  rd_data = rx_byte;
          IDX_TC_LO: rd_data = cfg[IDX_TC_LO];
          IDX_TC_HI: rd_data = cfg[IDX_TC_HI];
          default:   rd_data = '0;
        endcase
    end
  end

  // R3
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pointed |=> (ptr == '0));

  // R4
  cmd_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && we && ptr == '0 && wdata[DW-1:PTR_W] != '0) |=> (ptr == '0));

  // R5
  status_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_acc && !we && ptr == '0) |=> (ptr == '0));

  // R7
  data_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && dport && !clr) |=> (ptr == $past(ptr)));
endmodule

// File: rtl/dual_chan_regif.sv
module dual_chan_regif
  import regif_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cs,
  input  logic                               we,
  input  logic [CSEL_W-1:0]                  chan,
  input  logic                               dport,
  input  logic [DW-1:0]                      wdata,
  output logic [DW-1:0]                      rdata,
  input  logic [NCH-1:0][DW-1:0]             status_in,
  input  logic [NCH-1:0][DW-1:0]             rx_byte,
  output logic [NCH-1:0]                     tx_load,
  output logic [DW-1:0]                      tx_byte,
  output logic [NCH-1:0]                     rx_pop,
  output logic [NCH-1:0]                     chan_rst,
  output logic [NCH-1:0][NREG-1:0][DW-1:0]   chan_cfg
);
  logic [NCH-1:0]            wr9;
  logic [NCH-1:0][DW-1:0]    rd;
  logic [NCH-1:0][PTR_W-1:0] ptr_q;
  logic [DW-1:0]             master;

  assign tx_byte = wdata;

  regif_master u_master (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr9    (wr9),
    .wdata  (wdata),
    .master (master),
    .clr    (chan_rst)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = cs && (chan == CSEL_W'(c));

    regif_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_c),
      .we      (we),
      .dport   (dport),
      .wdata   (wdata),
      .clr     (chan_rst[c]),
      .status  (status_in[c]),
      .rx_byte (rx_byte[c]),
      .master  (master),
      .ptr     (ptr_q[c]),
      .cfg     (chan_cfg[c]),
      .tx_load (tx_load[c]),
      .rx_pop  (rx_pop[c]),
      .wr9_hit (wr9[c]),
      .rd_data (rd[c])
    );

    // R10
    rst_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst[c] |=> (ptr_q[c] == '0 && chan_cfg[c][IDX_TC_LO] == '0));
  end

  assign rdata = rd[chan];

  // R6
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_load));

  // R7
  rx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_pop));
endmodule

// File: tb/dual_chan_regif_test.sv
module dual_chan_regif_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  // entry: {req[3:0], op[1:0] (1=write,2=read), chan, dport, data[7:0], expect[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'd5,  2'd2, 1'b0, 1'b0, 8'h00, 8'h05},  // R5 status at index 0
    {4'd5,  2'd2, 1'b0, 1'b0, 8'h00, 8'h05},  // R5 index stays 0
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h0C, 8'h00},  // R2 load 12
    {4'd8,  2'd1, 1'b0, 1'b0, 8'h7E, 8'h00},  // R8 store 12
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h0D, 8'h00},
    {4'd8,  2'd1, 1'b0, 1'b0, 8'h01, 8'h00},
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h0C, 8'h00},
    {4'd8,  2'd2, 1'b0, 1'b0, 8'h00, 8'h7E},  // R8 readback 12
    {4'd3,  2'd2, 1'b0, 1'b0, 8'h00, 8'h05},  // R3 back to 0
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h0D, 8'h00},
    {4'd8,  2'd2, 1'b0, 1'b0, 8'h00, 8'h01},  // R8 readback 13
    {4'd4,  2'd1, 1'b0, 1'b0, 8'h35, 8'h00},  // R4 command byte
    {4'd4,  2'd2, 1'b0, 1'b0, 8'h00, 8'h05},  // R4 index still 0
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h03, 8'h00},
    {4'd11, 2'd2, 1'b0, 1'b0, 8'h00, 8'h00},  // R11 index 3 reads 0
    {4'd3,  2'd2, 1'b0, 1'b0, 8'h00, 8'h05},
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h08, 8'h00},
    {4'd7,  2'd2, 1'b0, 1'b0, 8'h00, 8'h3C},  // R7 index 8 read
    {4'd3,  2'd2, 1'b0, 1'b0, 8'h00, 8'h05},
    {4'd7,  2'd2, 1'b0, 1'b1, 8'h00, 8'h3C},  // R7 data port read
    {4'd2,  2'd1, 1'b1, 1'b0, 8'h0C, 8'h00},  // B index 12
    {4'd12, 2'd2, 1'b0, 1'b0, 8'h00, 8'h05},  // R12 A unaffected
    {4'd8,  2'd1, 1'b1, 1'b0, 8'h99, 8'h00},
    {4'd2,  2'd1, 1'b1, 1'b0, 8'h0C, 8'h00},
    {4'd8,  2'd2, 1'b1, 1'b0, 8'h00, 8'h99},
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h0C, 8'h00},
    {4'd12, 2'd2, 1'b0, 1'b0, 8'h00, 8'h7E},  // R12 A copy kept
    {4'd2,  2'd1, 1'b0, 1'b0, 8'h0D, 8'h00},
    {4'd7,  2'd2, 1'b0, 1'b1, 8'h00, 8'h3C},  // R7 data read keeps index
    {4'd7,  2'd2, 1'b0, 1'b0, 8'h00, 8'h01},
    {4'd5,  2'd2, 1'b1, 1'b0, 8'h00, 8'h44},
    {4'd7,  2'd2, 1'b1, 1'b1, 8'h00, 8'hA7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, chan = 1'b0, dport = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0][7:0] status_in;
  logic [1:0][7:0] rx_byte;
  logic [1:0] tx_load, rx_pop, chan_rst;
  logic [7:0] tx_byte;
  logic [1:0][15:0][7:0] chan_cfg;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign status_in[0] = 8'h05;
  assign status_in[1] = 8'h44;
  assign rx_byte[0]   = 8'h3C;
  assign rx_byte[1]   = 8'hA7;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_chan_regif uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .chan(chan), .dport(dport),
    .wdata(wdata), .rdata(rdata), .status_in(status_in), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_pop(rx_pop),
    .chan_rst(chan_rst), .chan_cfg(chan_cfg)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus(input int op, input logic ch, input logic dp, input logic [7:0] d);
    @(negedge clk);
    cs = (op != 0);
    we = (op == 1);
    chan = ch;
    dport = dp;
    wdata = d;
    #1;
  endtask

  task automatic wr(input logic ch, input logic dp, input logic [7:0] d);
    bus(1, ch, dp, d);
  endtask

  task automatic idle();
    bus(0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cfg clear in reset", 32'(chan_cfg == '0), 32'd1);
    chk("R1 no strobes in reset", {26'd0, tx_load, rx_pop, chan_rst}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] op;
      rq = VEC[i][23:20];
      op = VEC[i][19:18];
      bus(int'(op), VEC[i][17], VEC[i][16], VEC[i][15:8]);
      if (op == 2'd2) begin
        checks++;
        if (rdata !== VEC[i][7:0]) begin
          fails++;
          $display("FAIL R%0d vector %0d: got %h expected %h", rq, i, rdata, VEC[i][7:0]);
        end
      end
    end

    // R8 configuration bus
    wr(0, 0, 8'h03); wr(0, 0, 8'hC1);
    wr(1, 0, 8'h05); wr(1, 0, 8'h6A);
    idle();
    chk("R8 cfg A[3]", chan_cfg[0][3], 8'hC1);
    chk("R8 cfg B[5]", chan_cfg[1][5], 8'h6A);
    chk("R8 cfg A[12]", chan_cfg[0][12], 8'h7E);

    // R10 reset B from channel A while B index is 14
    wr(1, 0, 8'h0E);
    wr(0, 0, 8'h09); wr(0, 0, 8'h48);
    chk("R10 chan_rst B pulse", chan_rst, 2'b10);
    idle();
    chk("R10 B cfg cleared", chan_cfg[1][5], 8'h00);
    chk("R10 B reg12 cleared", chan_cfg[1][12], 8'h00);
    chk("R10 A untouched", chan_cfg[0][3], 8'hC1);
    chk("R9 master via A", chan_cfg[0][9], 8'h08);
    chk("R9 master seen by B", chan_cfg[1][9], 8'h08);
    bus(2, 1, 0, 8'h00);
    chk("R10 B index cleared", rdata, 8'h44);

    // R10 reset A from channel B
    wr(1, 0, 8'h09); wr(1, 0, 8'h88);
    chk("R10 chan_rst A pulse", chan_rst, 2'b01);
    idle();
    chk("R10 A cfg cleared", chan_cfg[0][3], 8'h00);
    chk("R10 A reg12 cleared", chan_cfg[0][12], 8'h00);

    // R9 no-reset code written from B
    wr(1, 0, 8'h09); wr(1, 0, 8'h0B);
    chk("R10 code 00 no reset", chan_rst, 2'b00);
    idle();
    chk("R9 master via B", chan_cfg[0][9], 8'h0B);

    // R6 transmit path
    wr(0, 1, 8'h5A);
    chk("R6 data write strobe", tx_load, 2'b01);
    chk("R6 data write byte", tx_byte, 8'h5A);
    wr(1, 0, 8'h08); wr(1, 0, 8'hC3);
    chk("R6 index 8 strobe", tx_load, 2'b10);
    chk("R6 index 8 byte", tx_byte, 8'hC3);
    idle();
    chk("R6 strobe idle", tx_load, 2'b00);

    // R7 receive pop
    bus(2, 0, 1, 8'h00);
    chk("R7 data read pop", rx_pop, 2'b01);
    wr(1, 0, 8'h08);
    bus(2, 1, 0, 8'h00);
    chk("R7 index 8 read byte", rdata, 8'hA7);
    chk("R7 index 8 read pop", rx_pop, 2'b10);

    // R11 index 9 not readable
    wr(0, 0, 8'h09);
    bus(2, 0, 0, 8'h00);
    chk("R11 index 9 reads 0", rdata, 8'h00);

    // R10 full reset
    wr(0, 0, 8'h04); wr(0, 0, 8'h4C);
    wr(1, 0, 8'h0D); wr(1, 0, 8'h22);
    idle();
    chk("R8 cfg A[4]", chan_cfg[0][4], 8'h4C);
    chk("R8 cfg B[13]", chan_cfg[1][13], 8'h22);
    wr(0, 0, 8'h09); wr(0, 0, 8'hC5);
    chk("R10 full reset pulse", chan_rst, 2'b11);
    idle();
    chk("R10 full A cleared", chan_cfg[0][4], 8'h00);
    chk("R10 full B cleared", chan_cfg[1][13], 8'h00);
    chk("R10 full master cleared", chan_cfg[1][9], 8'h00);
    bus(2, 0, 0, 8'h00);
    chk("R5 status after full reset", rdata, 8'h05);
    idle();

    done = 1'b1;
    finish_run();
  end
endmodule